// File: doc/BRIEF.md
# Five-Level Restart Interrupt Controller

This block collects five interrupt requests for a CPU core and presents one of them at a time. The five sources are an unmaskable trap, three maskable restart sources (called R75, R65 and R55 here, from highest to lowest), and a general request whose vector the core fetches externally. Each raw input passes through a synchronizer before it is used. The trap is sensed on a rising edge but must also still be high. R75 is caught by a sticky edge latch. R65, R55 and the general request are sensed by level.

The core writes a 3-bit mask, and that write can also clear the R75 latch. The core raises and drops a global enable flag. It pulses an acknowledge when it takes the request that is presented. The block drives a request strobe, a restart vector, and a flag that says the vector must be fetched externally. It does not track which handler is running: after the enable flag is raised again, any pending request may be presented, whatever its priority.

Top module: `irq5_ctrl`

## Requirements
- R1: Pending requests are served in a fixed order, highest first: trap, R75, R65, R55, general. The vectors are 0x0024, 0x003C, 0x0034 and 0x002C. A general request gives `irq_ext`=1 with vector 0. With nothing pending, `irq_req`=0, `irq_vec`=0 and `irq_ext`=0.
- R2: A mask write with `mask_wr`=1 loads `mask_data`. Bit 0 masks R55, bit 1 masks R65 and bit 2 masks R75, and a 1 masks. Reset sets all three mask bits and clears the enable flag, so no request is presented after reset.
- R3: The trap is presented after a rising edge, only while it is still high, and whatever the mask or the enable flag. If it drops before it is accepted, the request is withdrawn.
- R4: A rising edge on R75 sets a latch, even while R75 is masked or the enable flag is low. A later unmask presents it, even if the input has already returned low.
- R5: The R75 latch is cleared when R75 is accepted, or by a mask write with `clr75`=1. A clear wins over an edge that arrives in the same cycle.
- R6: R65, R55 and the general request are presented only while their inputs are high, and are withdrawn when the inputs drop.
- R7: An `ack` while `irq_req`=1 accepts the presented source and clears the enable flag. An `ack` while `irq_req`=0 has no effect.
- R8: After an accepted trap, no new trap request appears while the input stays high. The input must go low and rise again.
- R9: `ei` sets the enable flag and `di` clears it. `di` wins over `ei`, and an acceptance wins over both. The R75, R65, R55 and general sources need the flag to be set.
- R10: A level source reaches `irq_req` two clock edges after its input changes. An edge source reaches it three edges after its rising edge.
- R11: There is no preemption state. After the enable flag is raised again, a lower-priority request is presented even though a higher one was accepted last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_in | input | 1 | Unmaskable trap request (raw) |
| r75_in | input | 1 | Edge-latched restart request (raw) |
| r65_in | input | 1 | Level restart request (raw) |
| r55_in | input | 1 | Level restart request (raw) |
| intr_in | input | 1 | General request, vector fetched externally (raw) |
| mask_wr | input | 1 | Mask write strobe |
| mask_data | input | 3 | New mask, 1 masks: bit 2 R75, bit 1 R65, bit 0 R55 |
| clr75 | input | 1 | With mask_wr, clears the R75 latch |
| ei | input | 1 | Set the enable flag |
| di | input | 1 | Clear the enable flag |
| ack | input | 1 | Core accepts the presented request |
| irq_req | output | 1 | A request is presented |
| irq_vec | output | VEC_W | Restart vector of the presented request |
| irq_ext | output | 1 | Presented request is the general one |
| ie_o | output | 1 | Global enable flag |

## Verification
The assertions check these rules on every cycle:
- An acceptance always clears the enable flag.
- The R75 latch holds until one of its clear conditions occurs.
- An accepted trap does not stay latched.
- Only the trap can be presented while the enable flag is low.
- A masked R65 is never presented.
- A presented trap always has its input still high.

Only the bench scenarios can show the following:
- The full priority order across every input, mask and enable pattern.
- The exact synchronizer latency.
- The fall-and-rise rearming of the trap.
- The capture of a short R75 pulse while it is masked.
- A lower-priority request is served after the flag is re-enabled.

// File: rtl/irq5_ctrl.sv
module irq5_ctrl #(
  parameter int SYNC_STAGES = 2,
  parameter int VEC_W = 16,
  parameter logic [VEC_W-1:0] VEC_TRAP = 16'h0024,
  parameter logic [VEC_W-1:0] VEC_R75  = 16'h003C,
  parameter logic [VEC_W-1:0] VEC_R65  = 16'h0034,
  parameter logic [VEC_W-1:0] VEC_R55  = 16'h002C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trap_in,
  input  logic             r75_in,
  input  logic             r65_in,
  input  logic             r55_in,
  input  logic             intr_in,
  input  logic             mask_wr,
  input  logic [2:0]       mask_data,
  input  logic             clr75,
  input  logic             ei,
  input  logic             di,
  input  logic             ack,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec,
  output logic             irq_ext,
  output logic             ie_o
);
  localparam int NSRC = 5;
  localparam int S_INTR = 0, S_R55 = 1, S_R65 = 2, S_R75 = 3, S_TRAP = 4;

  logic [NSRC-1:0] raw, lvl, lvl_d, rise, pend, grant;
  logic [NSRC-1:0] sync_q [SYNC_STAGES];
  logic [2:0] mask_q;
  logic ie_q, trap_lat, r75_lat, accept;

  assign raw  = {trap_in, r75_in, r65_in, r55_in, intr_in};
  assign lvl  = sync_q[SYNC_STAGES-1];
  assign rise = lvl & ~lvl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
      lvl_d <= '0;
    end else begin
      sync_q[0] <= raw;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      lvl_d <= lvl;
    end
  end

  assign pend[S_TRAP] = trap_lat & lvl[S_TRAP];
  assign pend[S_R75]  = r75_lat & ~mask_q[2] & ie_q;
  assign pend[S_R65]  = lvl[S_R65] & ~mask_q[1] & ie_q;
  assign pend[S_R55]  = lvl[S_R55] & ~mask_q[0] & ie_q;
  assign pend[S_INTR] = lvl[S_INTR] & ie_q;

  always_comb begin
    grant = '0;
    if      (pend[S_TRAP]) grant[S_TRAP] = 1'b1;
    else if (pend[S_R75])  grant[S_R75]  = 1'b1;
    else if (pend[S_R65])  grant[S_R65]  = 1'b1;
    else if (pend[S_R55])  grant[S_R55]  = 1'b1;
    else if (pend[S_INTR]) grant[S_INTR] = 1'b1;
  end

  always_comb begin
    irq_vec = '0;
    if (grant[S_TRAP]) irq_vec = VEC_TRAP;
    if (grant[S_R75])  irq_vec = VEC_R75;
    if (grant[S_R65])  irq_vec = VEC_R65;
    if (grant[S_R55])  irq_vec = VEC_R55;
  end

  assign irq_req = |pend;
  assign irq_ext = grant[S_INTR];
  assign accept  = ack & irq_req;
  assign ie_o    = ie_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_lat <= 1'b0;
      r75_lat  <= 1'b0;
      mask_q   <= 3'b111;
      ie_q     <= 1'b0;
    end else begin
      if ((accept && grant[S_TRAP]) || !lvl[S_TRAP]) trap_lat <= 1'b0;
      else if (rise[S_TRAP])                          trap_lat <= 1'b1;
      if ((accept && grant[S_R75]) || (mask_wr && clr75)) r75_lat <= 1'b0;
      else if (rise[S_R75])                               r75_lat <= 1'b1;
      if (mask_wr) mask_q <= mask_data;
      if (accept)  ie_q <= 1'b0;
      else if (di) ie_q <= 1'b0;
      else if (ei) ie_q <= 1'b1;
    end
  end

  a_r7_accept_clears_ie: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ie_q);
  a_r4_r75_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (r75_lat && !(accept && grant[S_R75]) && !(mask_wr && clr75)) |=> r75_lat);
  a_r8_trap_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && grant[S_TRAP]) |=> !trap_lat);
  a_r9_gated_by_ie: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !ie_q) |-> (irq_vec == VEC_TRAP && !irq_ext));
  a_r2_mask_respected: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_vec == VEC_R65) |-> !mask_q[1]);
  a_r3_trap_needs_level: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_vec == VEC_TRAP) |-> lvl[S_TRAP]);
endmodule

// File: tb/test_irq5_ctrl.sv
module test_irq5_ctrl;
  localparam int CLK_PERIOD = 10;
  logic clk = 0, rst_n = 0;
  logic trap_in = 0, r75_in = 0, r65_in = 0, r55_in = 0, intr_in = 0;
  logic mask_wr = 0, clr75 = 0, ei = 0, di = 0, ack = 0;
  logic [2:0] mask_data = 0;
  logic irq_req, irq_ext, ie_o;
  logic [15:0] irq_vec;
  int checks = 0, fails = 0;
  bit done = 0;

  irq5_ctrl i_irq5_ctrl (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [17:0] outv();
    return {irq_req, irq_ext, irq_vec};
  endfunction

  function automatic logic [17:0] expect_out(logic [4:0] src, logic [2:0] m, logic e);
    if (src[4])               return {2'b10, 16'h0024};
    if (src[3] && !m[2] && e) return {2'b10, 16'h003C};
    if (src[2] && !m[1] && e) return {2'b10, 16'h0034};
    if (src[1] && !m[0] && e) return {2'b10, 16'h002C};
    if (src[0] && e)          return {2'b11, 16'h0000};
    return 18'h0;
  endfunction

  task automatic wmask(logic [2:0] m, logic c);
    mask_wr = 1; mask_data = m; clr75 = c; tick(1);
    mask_wr = 0; clr75 = 0;
  endtask

  task automatic pulse_ack();
    ack = 1; tick(1); ack = 0;
  endtask

  task automatic set_ie(logic e);
    ei = e; di = !e; tick(1); ei = 0; di = 0;
  endtask

  task automatic drop_all();
    {trap_in, r75_in, r65_in, r55_in, intr_in} = 5'b0; tick(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    tick(2);
    chk("R2 reset out", outv(), 18'h0);
    chk("R2 reset ie", ie_o, 0);
    rst_n = 1; tick(1);
    r65_in = 1; tick(4);
    chk("R2 reset mask blocks r65", outv(), 18'h0);
    r65_in = 0; tick(4);

    // R1 R3 R6 R9 exhaustive sweep
    for (int s = 0; s < 32; s++)
      for (int m = 0; m < 8; m++)
        for (int e = 0; e < 2; e++) begin
          drop_all();
          wmask(m[2:0], 1);
          set_ie(e[0]);
          {trap_in, r75_in, r65_in, r55_in, intr_in} = s[4:0];
          tick(4);
          chk($sformatf("R1 sweep s=%0d m=%0d e=%0d", s, m, e), outv(),
              expect_out(s[4:0], m[2:0], e[0]));
        end

    // R10 latency
    drop_all(); wmask(3'b000, 1); set_ie(1);
    r65_in = 1; tick(1);
    chk("R10 level after 1 edge", irq_req, 0);
    tick(1);
    chk("R10 level after 2 edges", outv(), {2'b10, 16'h0034});
    r65_in = 0; tick(2);
    chk("R6 level withdrawn", irq_req, 0);
    trap_in = 1; tick(2);
    chk("R10 edge after 2 edges", irq_req, 0);
    tick(1);
    chk("R10 edge after 3 edges", outv(), {2'b10, 16'h0024});

    // R3 withdraw before accept
    trap_in = 0; tick(3);
    chk("R3 trap withdrawn", irq_req, 0);

    // R3 trap with ie low, R7 accept, R8 rearm
    set_ie(0);
    trap_in = 1; tick(4);
    chk("R3 trap with ie low", outv(), {2'b10, 16'h0024});
    pulse_ack();
    chk("R8 no re-request while held", irq_req, 0);
    tick(4);
    chk("R8 still none", irq_req, 0);
    trap_in = 0; tick(4); trap_in = 1; tick(4);
    chk("R8 rearmed after fall/rise", outv(), {2'b10, 16'h0024});
    pulse_ack(); trap_in = 0; tick(4);

    // R4 pulse while masked, then unmask
    wmask(3'b100, 1); set_ie(1);
    r75_in = 1; tick(1); r75_in = 0; tick(5);
    chk("R4 masked latch silent", irq_req, 0);
    wmask(3'b000, 0); tick(1);
    chk("R4 latched pulse after unmask", outv(), {2'b10, 16'h003C});
    pulse_ack();
    chk("R7 accept clears ie", ie_o, 0);
    set_ie(1);
    chk("R5 accept cleared latch", irq_req, 0);

    // R5 clear by mask write
    r75_in = 1; tick(1); r75_in = 0; tick(4);
    chk("R4 latch set", outv(), {2'b10, 16'h003C});
    wmask(3'b000, 1);
    chk("R5 mask write clears latch", irq_req, 0);

    // R5 clear wins over same-cycle edge (edge reaches latch 3 edges after drive)
    r75_in = 1; tick(2);
    mask_wr = 1; mask_data = 3'b000; clr75 = 1; tick(1);
    mask_wr = 0; clr75 = 0; r75_in = 0; tick(3);
    chk("R5 clear beats edge", irq_req, 0);

    // R7 ack without request
    set_ie(1); pulse_ack();
    chk("R7 idle ack no effect", ie_o, 1);

    // R9 di beats ei
    ei = 1; di = 1; tick(1); ei = 0; di = 0;
    chk("R9 di wins", ie_o, 0);

    // R11 lower-priority after re-enable
    set_ie(1);
    r75_in = 1; r55_in = 1; tick(4);
    chk("R11 r75 first", outv(), {2'b10, 16'h003C});
    pulse_ack(); r75_in = 0; set_ie(1);
    chk("R11 r55 after re-enable", outv(), {2'b10, 16'h002C});
    pulse_ack();
    chk("R7 ie cleared again", ie_o, 0);
    drop_all();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule